// File: doc/BRIEF.md
# Bank Mapper with Bank-Driven Nametable Page Select

This block is the bank-switching controller of a game cartridge. The CPU writes two registers. The first holds a select byte with two mode bits and a 3-bit target index. The second is a data port that loads whichever of eight bank registers the index names. From these registers the block translates the PPU address into the upper CHR ROM address bits and the CPU address into the upper PRG ROM address bits.

The block has no mirroring register. The nametable RAM page line (CIRAM A10) comes from bit 5 of a CHR bank register. The CHR-mode bit and the PPU address quadrant together pick which register supplies that bit. CHR ROM is limited to 32 KiB, so bit 5 of a bank number is never used as a CHR address bit. It only selects the nametable page.

Writes to the mirroring address, the interrupt-counter addresses or anything below $8000 are ignored.

Top module: `nt_bank_mapper`

## Requirements
- R1: After a synchronous active-high reset, all eight bank registers and both mode bits are zero. Every nametable quadrant then reads CIRAM A10 = 0, CHR at PPU $0000 gives bank 0, PRG at $8000 gives bank 0 and PRG at $E000 gives the last bank.
- R2: A write with A15=1, A14:A13=00 and A0=0 loads the select byte. Bit 7 is the CHR mode C, bit 6 is the PRG mode P and bits 2:0 are the target index. The same decode with A0=1 loads all 8 bits of the bank register named by the target index.
- R3: A CPU write outside A15=1, A14:A13=00 changes no register. This covers the $6000 range and the $C000 and $E000 ranges.
- R4: Writes to the mirroring addresses ($A000 and $A001) have no effect on CIRAM A10 or on any other output.
- R5: With C=0, the quadrants are numbered by PPU A11:A10. Quadrants 0 and 1 take CIRAM A10 from bit 5 of R0, and quadrants 2 and 3 take it from bit 5 of R1.
- R6: With C=1, quadrants 0, 1, 2 and 3 take CIRAM A10 from bit 5 of R2, R3, R4 and R5 respectively.
- R7: With C=0, setting bit 5 equal in R0 and R1 gives a single-screen arrangement, where all four quadrants read the same page. Setting them different gives horizontal mirroring.
- R8: With C=0, R0 and R1 map 2 KiB windows at PPU $0000 and $0800, with the bank's low bit replaced by PPU A10. R2, R3, R4 and R5 map 1 KiB windows at $1000, $1400, $1800 and $1C00.
- R9: With C=1, the two PPU halves swap. The 1 KiB windows from R2 to R5 sit at $0000 to $0C00, and the 2 KiB windows from R0 and R1 sit at $1000 and $1800.
- R10: The CHR bank output is bits 4:0 of the 1 KiB bank number. Bit 5 of a bank register never reaches it.
- R11: With P=0, PRG 8 KiB windows at $8000, $A000, $C000 and $E000 map to R6, R7, the second-to-last bank and the last bank. The PRG bank output is 6 bits, so the last bank is 63.
- R12: With P=1, $8000 maps to the second-to-last bank and $C000 maps to R6. $A000 stays R7 and $E000 stays the last bank.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; register writes take effect at its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cpu_addr | input | 16 | CPU address bus |
| cpu_data | input | 8 | CPU write data |
| cpu_wr | input | 1 | CPU write strobe, sampled at the clock edge |
| ppu_addr | input | 14 | PPU address bus |
| chr_bank | output | 5 | CHR ROM address bits 14:10 |
| prg_bank | output | 6 | PRG ROM address bits 18:13 |
| ciram_a10 | output | 1 | Nametable RAM page select |

## Verification
The bank registers are loaded with values whose bit 5 differs from quadrant to quadrant. All four nametable quadrants are then probed with C=0 and again with C=1, so a wrong register choice or a swapped quadrant changes the observed page. The same values carry distinct low bits, so every CHR window probe under both modes identifies the source register. It also exposes any leak of bit 5 into the CHR output.

Writes to the mirroring address, the interrupt-counter addresses and the $6000 range are followed by probes that would flip if any such write had been decoded. A final pair of R0/R1 values shows single-screen and horizontal arrangements. PRG probes in all four windows under both P settings separate the R6 and fixed-bank positions.

// File: rtl/mapper_pkg.sv
package mapper_pkg;

    localparam int NUM_BANK_REGS = 8;
    localparam int REG_W         = 8;
    localparam int IDX_W         = $clog2(NUM_BANK_REGS);

    typedef logic [REG_W-1:0] bank_reg_t;

    typedef struct packed {
        logic             chr_mode;
        logic             prg_mode;
        logic [IDX_W-1:0] target;
    } select_t;

    typedef enum logic [1:0] {
        WR_NONE   = 2'd0,
        WR_SELECT = 2'd1,
        WR_DATA   = 2'd2
    } wr_kind_e;

    function automatic wr_kind_e classify_write(input logic wr, input logic [15:0] addr);
        wr_kind_e kind;
        if (!wr || !addr[15] || (addr[14:13] != 2'b00))
            kind = WR_NONE;
        else if (addr[0])
            kind = WR_DATA;
        else
            kind = WR_SELECT;
        return kind;
    endfunction

endpackage

// File: rtl/mapper_bank_regs.sv
module mapper_bank_regs
    import mapper_pkg::*;
(
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           wr_en,
    input  logic [15:0]                    cpu_addr,
    input  logic [REG_W-1:0]               cpu_data,
    output select_t                        sel_q,
    output bank_reg_t [NUM_BANK_REGS-1:0]  bank_q
);

    wr_kind_e kind;
    assign kind = classify_write(wr_en, cpu_addr);

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_q  <= '0;
            bank_q <= '0;
        end else begin
            case (kind)
                WR_SELECT: begin
                    sel_q.chr_mode <= cpu_data[7];
                    sel_q.prg_mode <= cpu_data[6];
                    sel_q.target   <= cpu_data[IDX_W-1:0];
                end
                WR_DATA:   bank_q[sel_q.target] <= cpu_data;
                default:   ;
            endcase
        end
    end

    // R2: data port loads the register named by the previous select
    a_r2_data_load: assert property (@(posedge clk) disable iff (rst)
        (kind == WR_DATA) |=> (bank_q[$past(sel_q.target)] == $past(cpu_data)));

    // R2: select byte fields land in the mode bits and index
    a_r2_select_load: assert property (@(posedge clk) disable iff (rst)
        (kind == WR_SELECT) |=> (sel_q.chr_mode == $past(cpu_data[7]))
                              && (sel_q.prg_mode == $past(cpu_data[6])));

    // R3: writes outside the register window leave all state alone
    a_r3_off_window_stable: assert property (@(posedge clk) disable iff (rst)
        (wr_en && (!cpu_addr[15] || (cpu_addr[14:13] != 2'b00)))
        |=> ($stable(bank_q) && $stable(sel_q)));

    // R4: mirroring-address writes leave all state alone
    a_r4_mirror_ignored: assert property (@(posedge clk) disable iff (rst)
        (wr_en && (cpu_addr[15:13] == 3'b101)) |=> ($stable(bank_q) && $stable(sel_q)));

endmodule

// File: rtl/mapper_chr_xlate.sv
module mapper_chr_xlate
    import mapper_pkg::*;
#(
    parameter int CHR_BANK_W = 5,
    parameter int NT_BIT     = 5
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           chr_mode,
    input  bank_reg_t [NUM_BANK_REGS-1:0]  bank_q,
    input  logic [13:0]                    ppu_addr,
    output logic [CHR_BANK_W-1:0]          chr_bank,
    output logic                           ciram_a10
);

    localparam int NUM_QUAD = 4;

    logic      fine_half;
    bank_reg_t picked;
    bank_reg_t raw_bank;
    logic [NUM_QUAD-1:0] nt_page;

    // Upper PPU half (after the mode swap) holds the four 1 KiB windows
    assign fine_half = ppu_addr[12] ^ chr_mode;

    always_comb begin
        if (fine_half) begin
            picked   = bank_q[IDX_W'(2) + IDX_W'(ppu_addr[11:10])];
            raw_bank = picked;
        end else begin
            picked   = ppu_addr[11] ? bank_q[1] : bank_q[0];
            raw_bank = {picked[REG_W-1:1], ppu_addr[10]};
        end
    end

    assign chr_bank = raw_bank[CHR_BANK_W-1:0];

    // Per-quadrant nametable page source, picked by the CHR mode bit
    for (genvar q = 0; q < NUM_QUAD; q++) begin : g_quad
        assign nt_page[q] = chr_mode ? bank_q[2 + q][NT_BIT] : bank_q[q / 2][NT_BIT];
    end

    assign ciram_a10 = nt_page[ppu_addr[11:10]];

    // R5: in mode 0 the top and bottom pairs follow R0 and R1
    a_r5_pairs_mode0: assert property (@(posedge clk) disable iff (rst)
        (!chr_mode && ppu_addr[13] && !ppu_addr[11]) |-> (ciram_a10 == bank_q[0][NT_BIT]));

    // R6: in mode 1 the bottom-right quadrant follows R5
    a_r6_quad3_mode1: assert property (@(posedge clk) disable iff (rst)
        (chr_mode && ppu_addr[13] && (ppu_addr[11:10] == 2'b11)) |-> (ciram_a10 == bank_q[5][NT_BIT]));

    // R8: a 2 KiB window's low bank bit tracks PPU A10
    a_r8_low_bit_tracks_a10: assert property (@(posedge clk) disable iff (rst)
        (!ppu_addr[13] && !fine_half) |-> (chr_bank[0] == ppu_addr[10]));

endmodule

// File: rtl/mapper_prg_xlate.sv
module mapper_prg_xlate
    import mapper_pkg::*;
#(
    parameter int PRG_BANK_W = 6
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  prg_mode,
    input  bank_reg_t             bank_r6,
    input  bank_reg_t             bank_r7,
    input  logic [15:0]           cpu_addr,
    output logic [PRG_BANK_W-1:0] prg_bank
);

    localparam logic [PRG_BANK_W-1:0] LAST_BANK   = '1;
    localparam logic [PRG_BANK_W-1:0] SECOND_LAST = LAST_BANK - PRG_BANK_W'(1);

    logic [PRG_BANK_W-1:0] r6_bank;
    logic [PRG_BANK_W-1:0] r7_bank;

    assign r6_bank = bank_r6[PRG_BANK_W-1:0];
    assign r7_bank = bank_r7[PRG_BANK_W-1:0];

    always_comb begin
        case (cpu_addr[14:13])
            2'b00:   prg_bank = prg_mode ? SECOND_LAST : r6_bank;
            2'b01:   prg_bank = r7_bank;
            2'b10:   prg_bank = prg_mode ? r6_bank : SECOND_LAST;
            default: prg_bank = LAST_BANK;
        endcase
    end

    // R11: the top window is always the last bank
    a_r11_last_fixed: assert property (@(posedge clk) disable iff (rst)
        (cpu_addr[15:13] == 3'b111) |-> (prg_bank == LAST_BANK));

    // R12: the fixed second-to-last bank never appears at $A000
    a_r12_a000_is_r7: assert property (@(posedge clk) disable iff (rst)
        (cpu_addr[15:13] == 3'b101) |-> (prg_bank == bank_r7[PRG_BANK_W-1:0]));

endmodule

// File: rtl/nt_bank_mapper.sv
module nt_bank_mapper
    import mapper_pkg::*;
#(
    parameter int CHR_BANK_W = 5,
    parameter int PRG_BANK_W = 6,
    parameter int NT_BIT     = 5
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [15:0]           cpu_addr,
    input  logic [7:0]            cpu_data,
    input  logic                  cpu_wr,
    input  logic [13:0]           ppu_addr,
    output logic [CHR_BANK_W-1:0] chr_bank,
    output logic [PRG_BANK_W-1:0] prg_bank,
    output logic                  ciram_a10
);

    select_t                       sel_q;
    bank_reg_t [NUM_BANK_REGS-1:0] bank_q;

    mapper_bank_regs u_regs (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (cpu_wr),
        .cpu_addr (cpu_addr),
        .cpu_data (cpu_data),
        .sel_q    (sel_q),
        .bank_q   (bank_q)
    );

    mapper_chr_xlate #(
        .CHR_BANK_W (CHR_BANK_W),
        .NT_BIT     (NT_BIT)
    ) u_chr (
        .clk       (clk),
        .rst       (rst),
        .chr_mode  (sel_q.chr_mode),
        .bank_q    (bank_q),
        .ppu_addr  (ppu_addr),
        .chr_bank  (chr_bank),
        .ciram_a10 (ciram_a10)
    );

    mapper_prg_xlate #(
        .PRG_BANK_W (PRG_BANK_W)
    ) u_prg (
        .clk      (clk),
        .rst      (rst),
        .prg_mode (sel_q.prg_mode),
        .bank_r6  (bank_q[6]),
        .bank_r7  (bank_q[7]),
        .cpu_addr (cpu_addr),
        .prg_bank (prg_bank)
    );

endmodule

// File: tb/sim_nt_bank_mapper.sv
module sim_nt_bank_mapper;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] cpu_addr = 16'h0000;
    logic [7:0]  cpu_data = 8'h00;
    logic        cpu_wr = 1'b0;
    logic [13:0] ppu_addr = 14'h0000;
    logic [4:0]  chr_bank;
    logic [5:0]  prg_bank;
    logic        ciram_a10;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    typedef struct {
        int    kind;   // 0 = ciram, 1 = chr, 2 = prg
        int    exp;
        string tag;
    } item_t;

    item_t sb[$];

    nt_bank_mapper u0 (
        .clk       (clk),
        .rst       (rst),
        .cpu_addr  (cpu_addr),
        .cpu_data  (cpu_data),
        .cpu_wr    (cpu_wr),
        .ppu_addr  (ppu_addr),
        .chr_bank  (chr_bank),
        .prg_bank  (prg_bank),
        .ciram_a10 (ciram_a10)
    );

    always #10 clk = ~clk;

    // Driver: one CPU write per call
    task automatic cpu_write(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        cpu_addr = a;
        cpu_data = d;
        cpu_wr   = 1'b1;
        @(negedge clk);
        cpu_wr   = 1'b0;
    endtask

    // Driver: set a probe address and push the expected result
    task automatic probe(input int kind, input logic [15:0] addr, input int exp, input string tag);
        item_t it;
        @(negedge clk);
        if (kind == 2) cpu_addr = addr;
        else           ppu_addr = addr[13:0];
        it.kind = kind;
        it.exp  = exp;
        it.tag  = tag;
        sb.push_back(it);
    endtask

    task automatic nt_all(input int e0, input int e1, input int e2, input int e3, input string tag);
        probe(0, 16'h2000, e0, tag);
        probe(0, 16'h2400, e1, tag);
        probe(0, 16'h2800, e2, tag);
        probe(0, 16'h2C00, e3, tag);
    endtask

    // Monitor: pops one expected item per cycle and compares
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (sb.size() > 0) begin
                item_t it;
                int got;
                it = sb.pop_front();
                case (it.kind)
                    0:       got = int'(ciram_a10);
                    1:       got = int'(chr_bank);
                    default: got = int'(prg_bank);
                endcase
                checks++;
                if (got != it.exp) begin
                    errors++;
                    $display("FAIL %s kind=%0d: actual %0d expected %0d", it.tag, it.kind, got, it.exp);
                end
            end
        end
    end

    initial begin
        #(20 * 100000);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    // Bank values: R0=0x26 R1=0x0B R2=0x31 R3=0x02 R4=0x1F R5=0x24 R6=0x45 R7=0x3A
    initial begin
        logic [7:0] vals [8];
        vals[0] = 8'h26; vals[1] = 8'h0B; vals[2] = 8'h31; vals[3] = 8'h02;
        vals[4] = 8'h1F; vals[5] = 8'h24; vals[6] = 8'h45; vals[7] = 8'h3A;

        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        nt_all(0, 0, 0, 0, "R1");
        probe(1, 16'h0000, 0, "R1");
        probe(2, 16'h8000, 0, "R1");
        probe(2, 16'hE000, 63, "R1");

        // R2: load all bank registers through select + data, C=0 P=0
        for (int i = 0; i < 8; i++) begin
            cpu_write(16'h8000, 8'(i));
            cpu_write(16'h8001, vals[i]);
        end

        // R5, R7: mode 0 quadrants (horizontal: R0 bit5=1, R1 bit5=0)
        nt_all(1, 1, 0, 0, "R5");
        // R8, R10: mode 0 CHR windows
        probe(1, 16'h0000, 6,  "R8");
        probe(1, 16'h0400, 7,  "R8");
        probe(1, 16'h0800, 10, "R8");
        probe(1, 16'h0C00, 11, "R8");
        probe(1, 16'h1000, 17, "R10");
        probe(1, 16'h1400, 2,  "R8");
        probe(1, 16'h1800, 31, "R8");
        probe(1, 16'h1C00, 4,  "R10");
        // R11: PRG with P=0
        probe(2, 16'h8000, 5,  "R11");
        probe(2, 16'hA000, 58, "R11");
        probe(2, 16'hC000, 62, "R11");
        probe(2, 16'hE000, 63, "R11");

        // R2: select byte sets C=1 and P=1
        cpu_write(16'h8000, 8'hC0);
        // R6: mode 1 quadrants
        nt_all(1, 0, 0, 1, "R6");
        // R9: mode 1 CHR windows
        probe(1, 16'h0000, 17, "R9");
        probe(1, 16'h0400, 2,  "R9");
        probe(1, 16'h0800, 31, "R9");
        probe(1, 16'h0C00, 4,  "R9");
        probe(1, 16'h1000, 6,  "R9");
        probe(1, 16'h1400, 7,  "R9");
        probe(1, 16'h1800, 10, "R9");
        probe(1, 16'h1C00, 11, "R9");
        // R12: PRG with P=1
        probe(2, 16'h8000, 62, "R12");
        probe(2, 16'hA000, 58, "R12");
        probe(2, 16'hC000, 5,  "R12");
        probe(2, 16'hE000, 63, "R12");

        // R4: mirroring writes change nothing
        cpu_write(16'hA000, 8'h00);
        cpu_write(16'hA000, 8'hFF);
        cpu_write(16'hA001, 8'h00);
        nt_all(1, 0, 0, 1, "R4");

        // R3: target R2, then writes outside the window
        cpu_write(16'h8000, 8'h82);
        cpu_write(16'h6001, 8'h00);
        cpu_write(16'hE000, 8'h00);
        cpu_write(16'hC001, 8'h00);
        cpu_write(16'hC000, 8'h00);
        probe(0, 16'h2000, 1, "R3");
        probe(0, 16'h2C00, 1, "R3");
        probe(1, 16'h1000, 6, "R3");

        // R2: the data port now reaches R2
        cpu_write(16'h8001, 8'h00);
        probe(0, 16'h2000, 0, "R2");
        probe(1, 16'h0000, 0, "R2");

        // R7: single screen with C=0, R0 and R1 both bit5=1
        cpu_write(16'h8001, 8'h20);
        cpu_write(16'h8000, 8'h01);
        cpu_write(16'h8001, 8'h20);
        nt_all(1, 1, 1, 1, "R7");

        while (sb.size() > 0) @(negedge clk);
        repeat (2) @(negedge clk);
        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule